// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider Controller

This block sits after an external dual-modulus prescaler in a frequency synthesizer's feedback path. It is clocked by the prescaler's output and counts that output with two cascaded down-counters: a main counter of programmable length B and a swallow counter of programmable length A. While the swallow counter is still counting, the block asks the prescaler to divide by P+1. For the rest of the main count it asks for P. One divided pulse therefore appears every P·B + A prescaler input cycles, and that pulse feeds the phase detector.

The base ratio P is 8, 16 or 32, chosen by a two-bit mode. A setting that cannot be built (a reserved mode, A not below P, B below A, or B of zero) raises an error flag, and the divider keeps the settings it already has. New settings are taken only at the point where a divide cycle ends, so no cycle is ever cut short. The smallest ratio that every integer above it can reach is P·(P−1), which is 56, 240 or 992. Removing the enable parks both counters and silences both outputs.

Top module: `divctl_top`

## Requirements
- R1: While reset is asserted and after its release with the enable low, `mod_sel` and `fb_pulse` are low.
- R2: With a valid setting, the prescaler input cycles between the start of a divide cycle and its `fb_pulse` clock, counted as P+1 for each clock with `mod_sel` high and P for each clock with it low, total P·B + A. The encodings are `ps_mode` 0 → P=8, 1 → P=16, 2 → P=32, and 3 is reserved.
- R3: In each divide cycle, `mod_sel` is high on the first A clocks and low on the remaining B−A clocks.
- R4: `fb_pulse` is high for exactly one clock, the B-th clock of each divide cycle, so consecutive pulses are B clocks apart.
- R5: The first rising edge at which `enable` is seen high while the block is idle starts a divide cycle. The first clock of that cycle follows that edge.
- R6: From the clock after `enable` is sampled low, both outputs stay low. Raising `enable` again starts a fresh divide cycle from its first clock.
- R7: `cfg_err` is high, without a clock, whenever `ps_mode` is 3, `swal_val` ≥ P, `main_val` < `swal_val`, or `main_val` is 0. Otherwise it is low.
- R8: When the settings are invalid at a cycle boundary, the divider keeps running with the settings it last accepted. After reset these are P=8, B=1, A=0.
- R9: Settings changed in the middle of a divide cycle do not affect that cycle. They apply from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pre_clk | input | 1 | Prescaler output clock; clocks both counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low parks the divider |
| ps_mode | input | 2 | Prescaler base ratio select (0:8, 1:16, 2:32, 3:reserved) |
| main_val | input | 13 | Main count B |
| swal_val | input | 5 | Swallow count A |
| mod_sel | output | 1 | High requests divide by P+1 from the prescaler |
| fb_pulse | output | 1 | One-clock pulse once per divide cycle to the phase detector |
| cfg_err | output | 1 | Present setting is not valid |

## Verification
The assertions assume that `enable`, `ps_mode`, `main_val` and `swal_val` change only between rising edges of the prescaler clock. They also assume that the bench's count of input cycles, P or P+1 per clock according to `mod_sel`, stands in for the real prescaler. The bench meets these assumptions by driving every input on the falling edge. It sweeps each mode over values of A that include 0, 1, P/2 and P−1, with B equal to A, just above A and above P. It changes settings either at a boundary or in the middle of a cycle, always at a known position.

// File: rtl/divctl_pkg.sv
package divctl_pkg;

   typedef enum logic [1:0] {
      PS_DIV8  = 2'd0,
      PS_DIV16 = 2'd1,
      PS_DIV32 = 2'd2,
      PS_RSVD  = 2'd3
   } ps_mode_e;

   // base ratio for a mode code, zero for the reserved code
   function automatic int unsigned ps_ratio(input logic [1:0] code);
      if (code == PS_RSVD) return 0;
      return 32'd8 << code;
   endfunction

endpackage

// File: rtl/divctl_cfg.sv
module divctl_cfg
   import divctl_pkg::*;
#(
   parameter int B_W      = 13,
   parameter int A_W      = 5,
   parameter int RST_MODE = 0,
   parameter int RST_B    = 1,
   parameter int RST_A    = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [1:0]     mode_in,
   input  logic [B_W-1:0] b_in,
   input  logic [A_W-1:0] a_in,
   output logic [B_W-1:0] b_nxt,
   output logic [A_W-1:0] a_nxt,
   output logic           bad
);

   localparam int PAD_W = B_W - A_W;

   logic [1:0]     mode_q;
   logic [B_W-1:0] b_q;
   logic [A_W-1:0] a_q;
   logic [B_W-1:0] a_wide;

   assign a_wide = {{PAD_W{1'b0}}, a_in};

   always_comb begin
      bad = 1'b0;
      if (mode_in == PS_RSVD)               bad = 1'b1;
      if (32'(a_in) >= ps_ratio(mode_in))   bad = 1'b1;
      if (b_in < a_wide)                    bad = 1'b1;
      if (b_in == '0)                       bad = 1'b1;
   end

   assign b_nxt = bad ? b_q : b_in;
   assign a_nxt = bad ? a_q : a_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 2'(RST_MODE);
         b_q    <= B_W'(RST_B);
         a_q    <= A_W'(RST_A);
      end else if (load) begin
         mode_q <= bad ? mode_q : mode_in;
         b_q    <= b_nxt;
         a_q    <= a_nxt;
      end
   end

   // R8
   cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && bad) |=> ($stable(b_q) && $stable(a_q) && $stable(mode_q)));

   // R9
   cfg_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load) |=> ($stable(b_q) && $stable(a_q) && $stable(mode_q)));

endmodule

// File: rtl/divctl_main_cnt.sv
module divctl_main_cnt #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] len,
   output logic [W-1:0] cnt,
   output logic         at_zero
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= len - W'(1);
      else if (step)  cnt <= cnt - W'(1);
   end

   assign at_zero = (cnt == '0);

   // R4
   main_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/divctl_swallow_cnt.sv
module divctl_swallow_cnt #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] len,
   output logic [W-1:0] cnt,
   output logic         busy
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (load)                 cnt <= len;
      else if (step && cnt != '0)    cnt <= cnt - W'(1);
   end

   assign busy = (cnt != '0);

   // R3
   swallow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/divctl_top.sv
module divctl_top
   import divctl_pkg::*;
#(
   parameter int B_W      = 13,
   parameter int A_W      = 5,
   parameter int RST_MODE = 0,
   parameter int RST_B    = 1,
   parameter int RST_A    = 0
) (
   input  logic           pre_clk,
   input  logic           rst_n,
   input  logic           enable,
   input  logic [1:0]     ps_mode,
   input  logic [B_W-1:0] main_val,
   input  logic [A_W-1:0] swal_val,
   output logic           mod_sel,
   output logic           fb_pulse,
   output logic           cfg_err
);

   localparam int MAX_P = 32;

   generate
      if (A_W < $clog2(MAX_P) || B_W <= A_W) begin : g_width_bad
         $error("divctl_top: swallow width too small or main width not above it");
      end
      if (RST_MODE > 2 || RST_B < 1 || RST_A > RST_B ||
          RST_A >= int'(ps_ratio(2'(RST_MODE)))) begin : g_reset_bad
         $error("divctl_top: reset setting is not a valid divide setting");
      end
   endgenerate

   logic           run;
   logic           load;
   logic           step;
   logic           main_zero;
   logic           swal_busy;
   logic [B_W-1:0] b_nxt;
   logic [A_W-1:0] a_nxt;
   logic [B_W-1:0] main_cnt;
   logic [A_W-1:0] swal_cnt;

   always_ff @(posedge pre_clk or negedge rst_n) begin
      if (!rst_n) run <= 1'b0;
      else        run <= enable;
   end

   assign load = enable && (!run || main_zero);
   assign step = enable && run && !main_zero;

   divctl_cfg #(
      .B_W(B_W), .A_W(A_W),
      .RST_MODE(RST_MODE), .RST_B(RST_B), .RST_A(RST_A)
   ) u_cfg (
      .clk(pre_clk), .rst_n(rst_n), .load(load),
      .mode_in(ps_mode), .b_in(main_val), .a_in(swal_val),
      .b_nxt(b_nxt), .a_nxt(a_nxt), .bad(cfg_err)
   );

   divctl_main_cnt #(.W(B_W)) u_main (
      .clk(pre_clk), .rst_n(rst_n), .load(load), .step(step),
      .len(b_nxt), .cnt(main_cnt), .at_zero(main_zero)
   );

   divctl_swallow_cnt #(.W(A_W)) u_swal (
      .clk(pre_clk), .rst_n(rst_n), .load(load), .step(step),
      .len(a_nxt), .cnt(swal_cnt), .busy(swal_busy)
   );

   assign mod_sel  = run && swal_busy;
   assign fb_pulse = run && main_zero;

   // R6
   quiet_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
      (!enable) |=> (!mod_sel && !fb_pulse));

   // R3
   swallow_fits_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
      run |-> (int'(swal_cnt) <= int'(main_cnt) + 1));

endmodule

// File: tb/tb_divctl_top.sv
module tb_divctl_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [12:0] bval = 13'd1;
   logic [4:0]  aval = 5'd0;
   logic        mod_sel, fb_pulse, cfg_err;

   int vecs = 0;
   int miss = 0;
   bit done = 0;

   always #10 clk = ~clk;

   divctl_top dut (
      .pre_clk(clk), .rst_n(rst_n), .enable(en), .ps_mode(mode),
      .main_val(bval), .swal_val(aval),
      .mod_sel(mod_sel), .fb_pulse(fb_pulse), .cfg_err(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vecs++;
      if (!ok) begin
         miss++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // sample n clocks starting at position start of a cycle of length b
   task automatic observe(input string tag, input int p, input int b, input int a,
                          input int start, input int n);
      int sum = 0;
      bit full = 0;
      for (int i = 0; i < n; i++) begin
         int pos = (start + i) % b;
         @(negedge clk);
         if (pos == 0) begin sum = 0; full = 1; end
         sum += mod_sel ? p + 1 : p;
         chk(mod_sel == (pos < a), {tag, " R3 mod_sel"}, int'(mod_sel), int'(pos < a));
         chk(fb_pulse == (pos == b - 1), {tag, " R4 fb_pulse"}, int'(fb_pulse), int'(pos == b - 1));
         if (pos == b - 1 && full)
            chk(sum == p * b + a, {tag, " R2 ratio"}, sum, p * b + a);
      end
   endtask

   // park, program, start; returns at the negedge of cycle position 0
   task automatic start_case(input int m, input int b, input int a);
      @(negedge clk);
      en = 1'b0; mode = 2'(m); bval = 13'(b); aval = 5'(a);
      @(negedge clk);
      chk(!mod_sel && !fb_pulse, "R6 idle", int'(mod_sel || fb_pulse), 0);
      en = 1'b1;
      @(negedge clk);
      chk(mod_sel == (a > 0), "R5 first mod_sel", int'(mod_sel), int'(a > 0));
      chk(fb_pulse == (b == 1), "R5 first fb_pulse", int'(fb_pulse), int'(b == 1));
   endtask

   task automatic err_case(input int m, input int b, input int a, input bit exp);
      @(negedge clk);
      mode = 2'(m); bval = 13'(b); aval = 5'(a);
      #1;
      chk(cfg_err == exp, "R7 cfg_err", int'(cfg_err), int'(exp));
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         vecs++; miss++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!mod_sel && !fb_pulse, "R1 in reset", int'(mod_sel || fb_pulse), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!mod_sel && !fb_pulse, "R1 after reset", int'(mod_sel || fb_pulse), 0);
      chk(cfg_err == 1'b0, "R7 valid reset inputs", int'(cfg_err), 0);

      // R7 decode of invalid settings
      err_case(3, 10, 2, 1'b1);
      err_case(0, 20, 8, 1'b1);
      err_case(1, 20, 16, 1'b1);
      err_case(2, 40, 31, 1'b0);
      err_case(0, 3, 4, 1'b1);
      err_case(1, 0, 0, 1'b1);
      err_case(0, 7, 7, 1'b0);

      // R2 R3 R4 R5 sweep over modes and swallow/main corners
      for (int m = 0; m < 3; m++) begin
         int p = 8 << m;
         int alist[4] = '{0, 1, p / 2, p - 1};
         foreach (alist[k]) begin
            int a = alist[k];
            int blist[3] = '{(a > 0) ? a : 1, a + 3, p + 2};
            foreach (blist[j]) begin
               int b = blist[j];
               start_case(m, b, a);
               observe("sweep", p, b, a, 1, 2 * b - 1);
            end
         end
      end

      // R8 invalid setting at boundary keeps old one
      start_case(0, 5, 2);
      observe("R8 pre", 8, 5, 2, 1, 4);
      aval = 5'd9;
      #1;
      chk(cfg_err == 1'b1, "R8 flag", int'(cfg_err), 1);
      observe("R8 kept", 8, 5, 2, 0, 10);

      // R8 invalid setting at first start uses reset default P=8 B=1 A=0
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      mode = 2'd3; bval = 13'd9; aval = 5'd1;
      en = 1'b1;
      observe("R8 default", 8, 1, 0, 0, 4);

      // R9 mid-cycle change waits for the boundary
      start_case(1, 20, 5);
      observe("R9 old", 16, 20, 5, 1, 5);
      mode = 2'd2; bval = 13'd10; aval = 5'd3;
      observe("R9 old tail", 16, 20, 5, 6, 14);
      observe("R9 new", 32, 10, 3, 0, 20);

      // R6 enable dropped mid-cycle, then restart
      start_case(0, 6, 3);
      observe("R6 pre", 8, 6, 3, 1, 2);
      en = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(!mod_sel && !fb_pulse, "R6 parked", int'(mod_sel || fb_pulse), 0);
      end
      en = 1'b1;
      observe("R6 restart", 8, 6, 3, 0, 12);

      done = 1;
      summary();
      $finish;
   end

endmodule